// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sits on the host side of a three-wire link to a serial digital-to-analog converter. A requester hands it an 8-bit output code and a 2-bit power mode over a valid/ready handshake. The block packs the pair into a 16-bit word and shifts it out most significant bit first on a frame-select line (`sync_o`), a serial clock (`sclk_o`) and a data line (`din_o`). The converter samples data on falling serial-clock edges and acts on the word at the 16th falling edge.

Between transfers all three lines rest low to save power, and the serial clock is stopped. Each transfer therefore opens with a frame-select high pulse of a fixed width in system clock cycles. A setup interval follows, with frame-select low, and then the 16 clock periods. The clock phase width, the pulse width and the setup interval are parameters. They are chosen so that the serial clock stays at or below 30 MHz, each phase lasts at least 13 ns and the pulse lasts at least 20 ns. With the 8 ns system clock of the bench, these defaults give phases of 24 ns, a 24 ns pulse and a 16 ns setup.

Back-pressure: `in_ready` is high only while the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the cycle in which `done_o` pulses. The requester may hold `in_valid` high while the block is busy, and the data it presents in that time is not used.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, and again whenever a frame has finished, `sync_o`, `sclk_o` and `din_o` are low, `in_ready` is high and `done_o` is low.
- R2: Each frame has exactly 16 falling `sclk_o` edges. The bits sampled on those edges, first to last, are word bits 15 down to 0. Bits 15:14 are 0, bits 13:12 are `in_mode[1:0]`, bits 11:4 are `in_code[7:0]` and bits 3:0 are 0.
- R3: `din_o` changes only together with a rising `sclk_o` edge or after the last falling edge, so it is stable at every falling edge.
- R4: Each frame starts with `sync_o` high for exactly SYNC_HI_CYC system cycles while `sclk_o` is low.
- R5: After `sync_o` falls, `sclk_o` stays low for exactly SETUP_CYC system cycles before its first rising edge.
- R6: Every high phase of `sclk_o`, and every low phase between two rising edges, lasts exactly HALF_CYC system cycles.
- R7: `in_ready` is high only when the block is idle. A request is accepted only when `in_valid` and `in_ready` are both high. `in_code` and `in_mode` presented while the block is busy do not affect any frame.
- R8: `done_o` is a one-cycle pulse that comes SYNC_HI_CYC + SETUP_CYC + 32*HALF_CYC cycles after `sync_o` rises, and `in_ready` is high in that same cycle.
- R9: `sync_o` stays low from its fall until after the 16th falling `sclk_o` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle and able to take a request |
| in_code | input | 8 | Converter output code |
| in_mode | input | 2 | Power mode field (0 is normal operation) |
| done_o | output | 1 | One-cycle pulse at frame end |
| sync_o | output | 1 | Frame-select line, idles low |
| sclk_o | output | 1 | Serial clock, idles low |
| din_o | output | 1 | Serial data, idles low |

## Verification
If the bit counter or the shift register goes wrong, the word captured at the falling edges no longer matches the packed request, and the bench sees this at the `done_o` pulse that ends the same frame. If the phase timer is off, it shows within one phase as a wrong pulse width, setup length or phase length, and it also moves the `done_o` pulse away from its fixed latency. If the state is wrong in idle, it shows in the very next cycle: `in_ready` is high while a line is active, or the lines are not low once `done_o` has pulsed.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 8;
  localparam int MODE_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } tx_state_t;

  // word layout: [15:14]=0, [13:12]=mode, [11:4]=code, [3:0]=0
  function automatic logic [FRAME_W-1:0] pack_word(input logic [CODE_W-1:0] code,
                                                   input logic [MODE_W-1:0] mode);
    return {2'b00, mode, code, 4'b0000};
  endfunction
endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));  // R6
endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (sr[W-1] == $past(sr[W-2])));  // R2
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_tx_pkg::*;
#(
  parameter int HALF_CYC    = 3,
  parameter int SYNC_HI_CYC = 3,
  parameter int SETUP_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [MODE_W-1:0] in_mode,
  output logic              done_o,
  output logic              sync_o,
  output logic              sclk_o,
  output logic              din_o
);
  localparam int MAXC1 = (HALF_CYC > SYNC_HI_CYC) ? HALF_CYC : SYNC_HI_CYC;
  localparam int MAXC  = (MAXC1 > SETUP_CYC) ? MAXC1 : SETUP_CYC;
  localparam int TW    = $clog2(MAXC + 1);
  localparam int BW    = $clog2(FRAME_W);

  tx_state_t      st;
  logic [BW-1:0]  bit_cnt;
  logic           accept, last_bit, tmr_exp, tmr_load, do_shift, sh_msb;
  logic [TW-1:0]  tmr_val;

  assign in_ready = (st == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign last_bit = (bit_cnt == BW'(FRAME_W - 1));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    do_shift = 1'b0;
    case (st)
      ST_IDLE:  if (accept)  begin tmr_load = 1'b1; tmr_val = TW'(SYNC_HI_CYC - 1); end
      ST_PULSE: if (tmr_exp) begin tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1); end
      ST_SETUP: if (tmr_exp) begin tmr_load = 1'b1; tmr_val = TW'(HALF_CYC - 1); do_shift = 1'b1; end
      ST_HIGH:  if (tmr_exp) begin tmr_load = 1'b1; tmr_val = TW'(HALF_CYC - 1); end
      ST_LOW:   if (tmr_exp && !last_bit) begin
                  tmr_load = 1'b1; tmr_val = TW'(HALF_CYC - 1); do_shift = 1'b1;
                end
      default: ;
    endcase
  end

  dac_tx_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  dac_tx_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(pack_word(in_code, in_mode)),
    .shift(do_shift), .msb(sh_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      sync_o  <= 1'b0;
      sclk_o  <= 1'b0;
      din_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_PULSE;
          sync_o <= 1'b1;
        end
        ST_PULSE: if (tmr_exp) begin
          st     <= ST_SETUP;
          sync_o <= 1'b0;
        end
        ST_SETUP: if (tmr_exp) begin
          st     <= ST_HIGH;
          sclk_o <= 1'b1;
          din_o  <= sh_msb;
        end
        ST_HIGH: if (tmr_exp) begin
          st     <= ST_LOW;
          sclk_o <= 1'b0;
        end
        ST_LOW: if (tmr_exp) begin
          if (last_bit) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            din_o   <= 1'b0;
            done_o  <= 1'b1;
          end else begin
            st      <= ST_HIGH;
            bit_cnt <= bit_cnt + 1'b1;
            sclk_o  <= 1'b1;
            din_o   <= sh_msb;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // run-length counters for width checks
  logic        sclk_q, sync_q;
  logic [15:0] sclk_run, sync_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; sync_q <= 1'b0; sclk_run <= '0; sync_run <= '0;
    end else begin
      sclk_q <= sclk_o;
      sync_q <= sync_o;
      sclk_run <= (sclk_o != sclk_q) ? 16'd1 : ((sclk_run != '1) ? sclk_run + 1'b1 : sclk_run);
      sync_run <= (sync_o != sync_q) ? 16'd1 : ((sync_run != '1) ? sync_run + 1'b1 : sync_run);
    end
  end

  AST_DIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(din_o));  // R3
  AST_SYNC_QUIET_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> !sclk_o);  // R4
  AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_o) |-> (sync_run >= 16'(SYNC_HI_CYC)));  // R4
  AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (sclk_run >= 16'(HALF_CYC)));  // R6
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!sync_o && !sclk_o && !din_o));  // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R8
  AST_SYNC_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !sync_o && !in_ready);  // R9
endmodule

// File: tb/tb_dac_frame_tx.sv
module tb_dac_frame_tx;
  import dac_tx_pkg::*;
  localparam int HALF = 3, SHI = 3, SET = 2;
  localparam int LAT = SHI + SET + 32 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_code = '0;
  logic [1:0] in_mode = '0;
  logic in_ready, done_o, sync_o, sclk_o, din_o;

  always #4 clk = ~clk;

  dac_frame_tx #(.HALF_CYC(HALF), .SYNC_HI_CYC(SHI), .SETUP_CYC(SET)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_mode(in_mode), .done_o(done_o),
    .sync_o(sync_o), .sclk_o(sclk_o), .din_o(din_o)
  );

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [7:0] c, input logic [1:0] m);
    logic [15:0] w;
    w = '0;
    w[13:12] = m;
    w[11:4]  = c;
    return w;
  endfunction

  // monitor: behaves as the receiving converter
  logic p_sync = 0, p_sclk = 0, p_din = 0, p_done = 0;
  int cyc = 0, hi_cnt = 0, set_cnt = 0, run = 0, edges = 0;
  bit set_on = 0, first_rise = 0, ph_bad = 0, din_bad = 0, rdy_bad = 0, sync_bad = 0;
  logic [15:0] word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sync_o && !p_sync) begin
        cyc = 0; hi_cnt = 0; edges = 0; word = '0;
        ph_bad = 0; din_bad = 0; rdy_bad = 0; sync_bad = 0; first_rise = 1;
      end
      cyc++;
      if (sync_o) hi_cnt++;
      if (!sync_o && p_sync) begin
        chk(hi_cnt == SHI, "R4", "sync high width", hi_cnt, SHI);
        set_on = 1; set_cnt = 0;
      end
      if (set_on && !sclk_o) set_cnt++;
      if (sclk_o == p_sclk) run++;
      else begin
        if (p_sclk) begin
          if (run != HALF) ph_bad = 1;
          if (din_o != p_din) din_bad = 1;
          word = {word[14:0], din_o};
          edges++;
        end else begin
          if (set_on) begin
            chk(set_cnt == SET, "R5", "setup cycles", set_cnt, SET);
            set_on = 0;
          end else if (!first_rise && run != HALF) ph_bad = 1;
          first_rise = 0;
        end
        run = 1;
      end
      if (sync_o && (sclk_o || edges != 0)) sync_bad = 1;
      if (in_ready && (sync_o || sclk_o)) rdy_bad = 1;
      if (done_o && p_done) chk(0, "R8", "done width", 2, 1);
      if (done_o) begin
        logic [15:0] e;
        n_done++;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
        chk(word === e, "R2", "frame word", word, e);
        chk(edges == 16, "R2", "falling edges", edges, 16);
        chk(!ph_bad, "R6", "sclk phase width", ph_bad, 0);
        chk(!din_bad, "R3", "din stable at fall", din_bad, 0);
        chk(!sync_bad, "R9", "sync low during bits", sync_bad, 0);
        chk(!rdy_bad, "R7", "ready low while busy", rdy_bad, 0);
        chk(cyc == LAT + 1, "R8", "done latency", cyc - 1, LAT);
        chk(in_ready && !sync_o && !sclk_o && !din_o, "R1", "idle at done",
            {in_ready, sync_o, sclk_o, din_o}, 4'b1000);
      end
    end
    p_sync = sync_o; p_sclk = sclk_o; p_din = din_o; p_done = done_o;
  end

  task automatic send(input logic [7:0] c, input logic [1:0] m, input bit hold);
    @(negedge clk);
    in_valid = 1; in_code = c; in_mode = m;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(c, m));
    @(negedge clk);
    if (hold) begin
      in_code = ~c; in_mode = ~m;   // R7: busy-time data must be ignored
      repeat (30) @(negedge clk);
    end
    in_valid = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(0, "R1", "watchdog expired", wd, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!sync_o && !sclk_o && !din_o && in_ready && !done_o, "R1", "reset state",
        {sync_o, sclk_o, din_o, in_ready, done_o}, 5'b00010);
    send(8'h00, 2'b00, 0);
    send(8'hFF, 2'b11, 0);
    send(8'hA5, 2'b01, 1);
    send(8'h5A, 2'b10, 0);
    for (int i = 0; i < 20; i++) begin
      send(8'($urandom_range(0, 255)), 2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    while (!in_ready || exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(n_done == 24, "R7", "frames sent", n_done, 24);
    chk(!sync_o && !sclk_o && !din_o && in_ready, "R1", "final idle",
        {sync_o, sclk_o, din_o, in_ready}, 4'b0001);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule